// File: doc/BRIEF.md
# Upward-Growing LIFO Stack Controller

The block keeps a stack pointer and a small internal word store, and offers push, pop and peek requests to a single client. The stack grows toward higher addresses. The pointer always names the next free slot. A push writes the incoming word at the pointer and then advances the pointer. A pop first steps the pointer back and then reads the word it now names. A peek reads the top entry and leaves the pointer where it is.

Read results (pop or peek) come back one clock after the request, together with a one-cycle valid strobe. The pointer's starting address comes from an input that is sampled while reset is held. The stack holds up to `DEPTH` words, at addresses base through base+DEPTH-1. Three sticky error flags record refused requests and stay set until the next reset:
- a push to a full stack,
- a pop or peek on an empty stack,
- a push that arrives in the same cycle as a pop.

Top module: `stack_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sp` is loaded with `base_addr`, the stack becomes empty, and `rd_valid`, `err_ovf`, `err_udf` and `err_coll` are cleared.
- R2: An accepted push stores `push_data` at the slot named by `sp` and raises `sp` by exactly one on the same edge.
- R3: An accepted pop lowers `sp` by one. One clock after the request, `rd_data` holds the word at the new `sp` and `rd_valid` is high for exactly one cycle.
- R4: Words come back in strict last-in, first-out order.
- R5: A push while `sp` equals base+DEPTH is refused. `sp` and the stored contents stay unchanged, and `err_ovf` is set.
- R6: A pop while `sp` equals base is refused. `sp` stays unchanged, `err_udf` is set, and no `rd_valid` strobe follows.
- R7: When push and pop are both high in one cycle, only the pop is performed. The push word is discarded and `err_coll` is set.
- R8: A peek on a non-empty stack returns the word at `sp`-1 one clock later with a one-cycle `rd_valid` strobe, and leaves `sp` and the contents unchanged. A peek in the same cycle as a push returns the top entry as it was before that push.
- R9: A peek on an empty stack sets `err_udf` and produces no `rd_valid` strobe.
- R10: When peek and pop are both high in one cycle, only the pop is performed.
- R11: Each error flag, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| base_addr | input | AW | Lowest stack address, sampled during reset |
| push | input | 1 | Push request |
| push_data | input | DW | Word to push |
| pop | input | 1 | Pop request |
| peek | input | 1 | Read top entry without moving the pointer |
| rd_data | output | DW | Word returned by the last pop or peek |
| rd_valid | output | 1 | One-cycle strobe marking new `rd_data` |
| sp | output | AW | Stack pointer, the next free address |
| err_ovf | output | 1 | Sticky: push refused on a full stack |
| err_udf | output | 1 | Sticky: pop or peek refused on an empty stack |
| err_coll | output | 1 | Sticky: push dropped because a pop arrived in the same cycle |

## Verification
A push can coincide with a pop, and a peek can coincide with either a pop or a push. These overlaps are the cases most likely to corrupt the pointer or return the wrong word. The bench raises the colliding request lines in the same cycle at the empty, partly filled and full levels, and for several base addresses. A cycle-level LIFO model in the bench judges each result: it applies the pop before the push, and it reads a peek before any push in that cycle. The bench then compares the pointer, the returned word, the strobe and the three sticky flags one clock later.

// File: rtl/stack_unit.sv
module stack_unit #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_addr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          peek,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] sp,
  output logic          err_ovf,
  output logic          err_udf,
  output logic          err_coll
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] base_q;
  logic [AW-1:0] cnt;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;

  assign cnt    = sp - base_q;
  assign wr_idx = cnt[IW-1:0];
  assign rd_idx = wr_idx - IW'(1);

  wire empty   = (cnt == '0);
  wire full    = (cnt == DEPTH_A);
  wire do_pop  = pop && !empty;
  wire do_peek = peek && !pop && !empty;
  wire do_push = push && !pop && !full;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp       <= base_addr;
      base_q   <= base_addr;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      err_ovf  <= 1'b0;
      err_udf  <= 1'b0;
      err_coll <= 1'b0;
    end else begin
      rd_valid <= do_pop || do_peek;
      if (do_pop || do_peek) rd_data <= mem[rd_idx];
      if (do_push)     sp <= sp + AW'(1);
      else if (do_pop) sp <= sp - AW'(1);
      err_ovf  <= err_ovf  | (push && !pop && full);
      err_udf  <= err_udf  | ((pop || peek) && empty);
      err_coll <= err_coll | (push && pop);
    end
  end

endmodule

// File: rtl/stack_unit_chk.sv
module stack_unit_chk #(
  parameter int AW    = 8,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          pop,
  input logic          peek,
  input logic          rd_valid,
  input logic [AW-1:0] sp,
  input logic [AW-1:0] base_q,
  input logic          err_ovf,
  input logic          err_udf,
  input logic          err_coll
);
  logic [AW-1:0] level;
  assign level = sp - base_q;

  p_push_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && level < AW'(DEPTH)) |=> sp == $past(sp) + AW'(1));

  p_pop_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && level != '0) |=> (rd_valid && sp == $past(sp) - AW'(1)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && level == AW'(DEPTH)) |=> ($stable(sp) && err_ovf));

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && level == '0) |=> (!rd_valid && $stable(sp) && err_udf));

  p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> err_coll);

  p_peek_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (peek && !pop && !push) |=> $stable(sp));

  p_peek_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (peek && !pop && level == '0) |=> (!rd_valid && err_udf));

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ovf || err_udf || err_coll) |=>
      ((err_ovf >= $past(err_ovf)) && (err_udf >= $past(err_udf)) && (err_coll >= $past(err_coll))));
endmodule

bind stack_unit stack_unit_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .peek(peek),
  .rd_valid(rd_valid), .sp(sp), .base_q(base_q),
  .err_ovf(err_ovf), .err_udf(err_udf), .err_coll(err_coll)
);

// File: tb/stack_unit_bench.sv
`timescale 1ns/1ps
module stack_unit_bench;
  localparam int DW = 8, DEPTH = 8, AW = 8;

  logic clk = 0, rst_n = 0, push = 0, pop = 0, peek = 0;
  logic [AW-1:0] base_addr = '0;
  logic [DW-1:0] push_data = '0;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] sp;
  logic rd_valid, err_ovf, err_udf, err_coll;

  int checks = 0, errors = 0;
  bit done = 0;
  int m [DEPTH];
  int n, base;
  int e_data;
  bit e_ovf, e_udf, e_coll;

  always #10 clk = ~clk;

  stack_unit #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_stack_unit (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .push(push),
    .push_data(push_data), .pop(pop), .peek(peek), .rd_data(rd_data),
    .rd_valid(rd_valid), .sp(sp), .err_ovf(err_ovf), .err_udf(err_udf),
    .err_coll(err_coll));

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic do_reset(int b);
    @(negedge clk);
    rst_n = 0; base_addr = AW'(b); push = 0; pop = 0; peek = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    base = b; n = 0; e_ovf = 0; e_udf = 0; e_coll = 0; e_data = 0;
    chk("R1", "sp", int'(sp), b);
    chk("R1", "rd_valid", int'(rd_valid), 0);
    chk("R1", "flags", int'({err_ovf, err_udf, err_coll}), 0);
  endtask

  task automatic step(bit pu, bit po, bit pk, int d, string req);
    bit ev = 0;
    push = pu; pop = po; peek = pk; push_data = DW'(d);
    if (po) begin
      if (n == 0) e_udf = 1;
      else begin n--; ev = 1; e_data = m[n]; end
    end else if (pk) begin
      if (n == 0) e_udf = 1;
      else begin ev = 1; e_data = m[n-1]; end
    end
    if (pu) begin
      if (po) e_coll = 1;
      else if (n == DEPTH) e_ovf = 1;
      else begin m[n] = d & 8'hff; n++; end
    end
    @(posedge clk);
    @(negedge clk);
    push = 0; pop = 0; peek = 0;
    chk(req, "sp", int'(sp), (base + n) & 8'hff);
    chk(req, "rd_valid", int'(rd_valid), int'(ev));
    if (ev) chk(req, "rd_data", int'(rd_data), e_data);
    chk("R11", "err_ovf", int'(err_ovf), int'(e_ovf));
    chk("R11", "err_udf", int'(err_udf), int'(e_udf));
    chk("R11", "err_coll", int'(err_coll), int'(e_coll));
  endtask

  initial begin
    int bases [3] = '{0, 37, 200};
    foreach (bases[k]) begin
      do_reset(bases[k]);
      for (int i = 0; i < DEPTH; i++) step(1, 0, 0, bases[k] + 7*i + 3, "R2");
      step(0, 0, 1, 0, "R8");
      step(0, 0, 0, 0, "R8");
      step(1, 0, 0, 99, "R5");
      step(0, 0, 1, 0, "R5");
      step(1, 1, 0, 55, "R7");
      step(0, 1, 1, 0, "R10");
      step(1, 0, 1, 77, "R8");
      for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, "R4");
      step(0, 1, 0, 0, "R6");
      step(0, 0, 0, 0, "R6");
      do_reset(bases[k]);
      step(0, 0, 1, 0, "R9");
      step(0, 0, 0, 0, "R9");
      step(0, 1, 1, 0, "R10");
      step(1, 0, 1, 17, "R8");
      step(1, 1, 0, 18, "R7");
      step(0, 0, 0, 0, "R7");
      for (int i = 0; i < 5; i++) step(1, 0, 0, 200 - i, "R2");
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R3");
      step(1, 0, 0, 250, "R2");
      for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R4");
      step(0, 0, 0, 0, "R3");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule